// File: doc/BRIEF.md
# Fractional n/32 Clock-Enable Divider

This block produces a clock-enable strobe whose average rate is a programmable fraction of the parent clock. Each window of 32 parent cycles lets through `mult` enables, spread as evenly as an integer accumulator allows, and a fixed post-divider then keeps one of every `FIXED_DIV` of those. The output rate is therefore parent × mult / (32 × FIXED_DIV). Downstream logic gates its registers with the strobe and does not need a second clock.

Software programs the ratio through a small register port. A 5-bit code sits at a build-time bit offset in the ratio register and holds 32 minus the wanted multiplier, so code 0 is full rate and code 31 is 1/32. A new code does nothing until software sets the commit flag in a second register. The hardware then switches ratio at the next 32-cycle window boundary and clears the flag on that same edge. Software polls the flag to learn that the change is done.

Top module: `frac_clken_div`

## Requirements
- R1: After reset the ratio code reads 0, the commit flag reads 0 and the block runs at full fractional rate (multiplier 32), so the output strobe rises 32 times in any 32 × FIXED_DIV consecutive cycles.
- R2: Reading register select 0 returns the 5-bit code at bits [FIELD_LSB+4:FIELD_LSB] and zero in every other bit; writing register select 0 stores only those five bits.
- R3: With committed code c, any span of 32 × FIXED_DIV × k consecutive cycles holds exactly k × (32 − c) output strobes.
- R4: Writing register select 1 with bit 31 set while the flag is clear sets the commit flag, which reads back at bit 31 of register select 1 and stays 1 until the ratio change is done.
- R5: A committed code takes effect only at a 32-cycle window boundary, and the commit flag clears on that same edge, so the flag is clear again no more than 32 cycles after it was set.
- R6: A write to the ratio code while the commit flag is set is discarded; the code reads back unchanged after the flag clears.
- R7: Writing a new ratio code without setting the commit flag leaves the output rate unchanged.
- R8: Strobes are spread evenly: with multiplier m, the gap between two successive output strobes lies between FIXED_DIV × floor(32/m) and FIXED_DIV × ceil(32/m) cycles, and no two strobes fall on adjacent cycles when FIXED_DIV is 2 or more.
- R9: A write to register select 1 with bit 31 clear leaves the commit flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 ratio register, 1 commit register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| clk_en_out | output | 1 | Divided clock-enable strobe |

## Verification
The hardest case to reach from the ports is a ratio write that lands while a commit is still waiting for its window boundary, since the flag lives for at most 32 cycles. The bench reads the flag as set on a falling edge and drives the competing write in that same half-cycle, so the write reaches the next rising edge while the flag is still known to be set. Rate checks count strobes over spans that are whole multiples of 32 × FIXED_DIV, which makes the expected count exact no matter where in the window counting starts.

// File: rtl/frac_clken_pkg.sv
package frac_clken_pkg;
  localparam int WIN_LEN  = 32;
  localparam int CODE_W   = 5;
  localparam int MULT_W   = 6;
  localparam int PHASE_W  = 5;
  localparam int DATA_W   = 32;
  localparam int FLAG_BIT = 31;

  typedef enum logic {
    SEL_RATIO  = 1'b0,
    SEL_COMMIT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frac_clken_regs.sv
module frac_clken_regs
  import frac_clken_pkg::*;
#(
  parameter int FIELD_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              boundary,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              kick,
  output logic [CODE_W-1:0] code,
  output logic [MULT_W-1:0] mult_active
);
  logic              kick_nxt;
  logic [CODE_W-1:0] code_nxt;
  logic [MULT_W-1:0] mult_nxt;
  logic              code_en;
  logic              apply_en;

  // The code field is locked while a commit waits for its boundary.
  always_comb begin
    code_en  = reg_wr && (reg_sel == SEL_RATIO) && !kick;
    apply_en = kick && boundary;
    code_nxt = code_en ? reg_wdata[FIELD_LSB +: CODE_W] : code;
    mult_nxt = apply_en ? MULT_W'(WIN_LEN) - MULT_W'(code) : mult_active;
    kick_nxt = kick;
    if (apply_en)
      kick_nxt = 1'b0;
    else if (reg_wr && (reg_sel == SEL_COMMIT) && reg_wdata[FLAG_BIT])
      kick_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick        <= 1'b0;
      code        <= '0;
      mult_active <= MULT_W'(WIN_LEN);
    end else begin
      kick <= kick_nxt;
      if (code_en)  code        <= code_nxt;
      if (apply_en) mult_active <= mult_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_RATIO)
      reg_rdata[FIELD_LSB +: CODE_W] = code;
    else
      reg_rdata[FLAG_BIT] = kick;
  end
endmodule

// File: rtl/frac_clken_accum.sv
module frac_clken_accum
  import frac_clken_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MULT_W-1:0] mult,
  output logic              boundary,
  output logic              frac_pulse
);
  localparam int SUM_W = MULT_W + 1;

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phase_nxt;
  logic [MULT_W-1:0]  acc;
  logic [MULT_W-1:0]  acc_nxt;
  logic [SUM_W-1:0]   sum;
  logic               pulse_nxt;

  always_comb begin
    boundary  = (phase == PHASE_W'(WIN_LEN - 1));
    phase_nxt = phase + 1'b1;
    sum       = SUM_W'(acc) + SUM_W'(mult);
    pulse_nxt = (sum >= SUM_W'(WIN_LEN));
    acc_nxt   = pulse_nxt ? MULT_W'(sum - SUM_W'(WIN_LEN)) : MULT_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      acc        <= '0;
      frac_pulse <= 1'b0;
    end else begin
      phase      <= phase_nxt;
      acc        <= acc_nxt;
      frac_pulse <= pulse_nxt;
    end
  end
endmodule

// File: rtl/frac_clken_postdiv.sv
module frac_clken_postdiv #(
  parameter int FIXED_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic en_out
);
  generate
    if (FIXED_DIV <= 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_out <= 1'b0;
        else        en_out <= pulse_in;
      end
    end else begin : g_div
      localparam int CNT_W = $clog2(FIXED_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(FIXED_DIV - 1);
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] cnt_nxt;
      logic             hit;

      always_comb begin
        hit     = pulse_in && (cnt == LAST);
        cnt_nxt = hit ? '0 : cnt + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt    <= '0;
          en_out <= 1'b0;
        end else begin
          if (pulse_in) cnt <= cnt_nxt;
          en_out <= hit;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/frac_clken_div.sv
module frac_clken_div
  import frac_clken_pkg::*;
#(
  parameter int FIELD_LSB = 8,
  parameter int FIXED_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        clk_en_out
);
  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic              boundary;
  logic              frac_pulse;
  logic              kick;
  logic [CODE_W-1:0] code;
  logic [MULT_W-1:0] mult_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  frac_clken_regs #(.FIELD_LSB(FIELD_LSB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .boundary   (boundary),
    .reg_rdata  (reg_rdata),
    .kick       (kick),
    .code       (code),
    .mult_active(mult_active)
  );

  frac_clken_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mult      (mult_active),
    .boundary  (boundary),
    .frac_pulse(frac_pulse)
  );

  frac_clken_postdiv #(.FIXED_DIV(FIXED_DIV)) u_post (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pulse_in(frac_pulse),
    .en_out  (clk_en_out)
  );
endmodule

// File: rtl/frac_clken_chk.sv
module frac_clken_chk #(
  parameter int FIXED_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       kick,
  input logic       boundary,
  input logic [4:0] code,
  input logic [5:0] mult_active,
  input logic       clk_en_out
);
  // R4
  kick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !boundary) |=> kick);

  // R5
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && boundary) |=> !kick);

  // R5
  mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(mult_active));

  // R6
  code_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> $stable(code));

  // R3
  mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_active >= 6'd1) && (mult_active <= 6'd32));

  generate
    if (FIXED_DIV > 1) begin : g_space
      // R8
      strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |=> !clk_en_out);
    end
  endgenerate
endmodule

bind frac_clken_div frac_clken_chk #(.FIXED_DIV(FIXED_DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .kick       (kick),
  .boundary   (boundary),
  .code       (code),
  .mult_active(mult_active),
  .clk_en_out (clk_en_out)
);

// File: tb/frac_clken_div_test.sv
module frac_clken_div_test;
  localparam int LSB  = 8;
  localparam int DIV  = 2;
  localparam int SPAN = 32 * DIV * 4;
  localparam int NVEC = 6;
  localparam logic [4:0] VEC_CODE [NVEC] = '{5'd0, 5'd31, 5'd16, 5'd27, 5'd1, 5'd10};
  localparam int         VEC_EXP  [NVEC] = '{128, 4, 64, 20, 124, 88};

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        clk_en_out;

  int n_chk;
  int n_err;
  int cycles;
  bit done;

  frac_clken_div #(.FIELD_LSB(LSB), .FIXED_DIV(DIV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_en_out(clk_en_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !done) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Called on a falling edge; returns on the falling edge after the write.
  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en_out) c++;
    end
  endtask

  task automatic wait_clear(output int polls);
    logic [31:0] d;
    polls = 0;
    rd(1'b1, d);
    while (d[31] && polls < 100) begin
      @(negedge clk);
      polls++;
      rd(1'b1, d);
    end
  endtask

  task automatic commit(input logic [4:0] c);
    int polls;
    logic [31:0] d;
    wr(1'b0, 32'(c) << LSB);
    wr(1'b1, 32'h8000_0000);
    rd(1'b1, d);
    check("R4 flag set after commit", int'(d[31]), 1);
    wait_clear(polls);
    check_range("R5 flag clears within one window", polls, 0, 32);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int cnt;
    int last;
    int gap_min;
    int gap_max;
    int polls;
    n_chk = 0; n_err = 0; cycles = 0; done = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, d);
    check("R1 ratio code after reset", int'(d), 0);
    rd(1'b1, d);
    check("R1 commit flag after reset", int'(d), 0);
    count_en(64, cnt);
    check("R1 full rate after reset", cnt, 32);

    // R3 table walk
    for (int v = 0; v < NVEC; v++) begin
      commit(VEC_CODE[v]);
      rd(1'b0, d);
      check("R2 code readback", int'(d), int'(32'(VEC_CODE[v]) << LSB));
      count_en(SPAN, cnt);
      check("R3 strobe count", cnt, VEC_EXP[v]);
    end

    // R8 spacing with multiplier 5: gaps 12..14
    commit(5'd27);
    last = -1; gap_min = 1000; gap_max = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (clk_en_out) begin
        if (last >= 0) begin
          if (i - last < gap_min) gap_min = i - last;
          if (i - last > gap_max) gap_max = i - last;
        end
        last = i;
      end
    end
    check_range("R8 minimum gap", gap_min, 12, 14);
    check_range("R8 maximum gap", gap_max, 12, 14);

    // R2 only the five code bits are stored
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d);
    check("R2 non-field bits read zero", int'(d), int'(32'h0000_1F00));

    // R7 uncommitted code leaves rate unchanged (still multiplier 5)
    repeat (4) @(negedge clk);
    count_en(SPAN, cnt);
    check("R7 rate unchanged without commit", cnt, 20);

    // R6 write during pending commit is discarded
    wr(1'b0, 32'(5'd20) << LSB);
    wr(1'b1, 32'h8000_0000);
    rd(1'b1, d);
    check("R4 flag set before locked write", int'(d[31]), 1);
    wr(1'b0, 32'(5'd3) << LSB);
    wait_clear(polls);
    check_range("R5 flag clears within one window", polls, 0, 32);
    rd(1'b0, d);
    check("R6 code unchanged by locked write", int'(d), int'(32'(5'd20) << LSB));
    repeat (4) @(negedge clk);
    count_en(SPAN, cnt);
    check("R6 rate follows committed code", cnt, 48);

    // R9 commit write with bit 31 clear
    wr(1'b1, 32'h7FFF_FFFF);
    rd(1'b1, d);
    check("R9 flag stays clear", int'(d), 0);
    repeat (4) @(negedge clk);
    count_en(SPAN, cnt);
    check("R9 rate unchanged", cnt, 48);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule